// File: doc/BRIEF.md
# Branch Trace Capture Buffer

This block records the control flow of a two-pipeline processor core while it runs. Each cycle it sees one completion strobe per pipeline, a strobe that marks a taken branch, and the address the branch went to. A running tally counts the instructions that completed since the last record. When a branch is taken, one record is formed from the target address and that tally, and the record goes into a small on-chip first-in first-out store. Because every record carries a completion tally, one slot covers a whole run of straight-line code and not a single instruction.

A debug reader drains records through a simple request/response port while capture goes on. A mode input picks what happens when the store is full. In wrap mode the newest record replaces the oldest, so the latest history is always present when a breakpoint hits, and a sticky flag notes that history was lost. In stop mode a full store raises a halt request to the core before any record can be lost. While that request is up, new branches are not stored but are counted. The request drops once the reader has taken at least one record and writes a clear.

Top module: `branch_trace_buf`

## Requirements
- R1: After a synchronous reset the store is empty (`buf_empty`=1), and `rd_valid`, `halt_req`, `overflow` and `drop_count` are all 0.
- R2: The tally grows by the number of active completion strobes (0, 1 or 2) each cycle. On a taken-branch cycle the record's count includes that cycle's completions, and the tally then restarts from 0.
- R3: The tally saturates at 16'hFFFF and does not wrap.
- R4: Records come out in arrival order. The store holds up to DEPTH (default 16) records, and each one reads as `rd_data` = {target[31:0], count[15:0]}, with the target in bits 47:16 and the count in bits 15:0.
- R5: A read request to a non-empty store gives `rd_valid`=1 with the oldest record one cycle later. A request to an empty store gives `rd_valid`=0 one cycle later.
- R6: A taken branch and a read request in the same cycle are both served.
- R7: In wrap mode (`mode_stop`=0), a branch into a full store with no read in that cycle drops the oldest record, stores the new one, and sets `overflow`.
- R8: In stop mode (`mode_stop`=1), the branch that fills the store raises `halt_req` on the next cycle. While `halt_req` is 1, taken branches are not stored, and each one adds 1 to `drop_count`.
- R9: A `trace_clr` pulse drops `halt_req` and zeroes `drop_count` only if at least one record has been read since `halt_req` rose. Otherwise the pulse leaves both unchanged.
- R10: A `trace_clr` pulse clears `overflow`.
- R11: Reads never pause capture. Branches taken while records are being drained are still stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| mode_stop | input | 1 | 0 = wrap when full, 1 = halt request when full |
| retire_p0 | input | 1 | Instruction completed in pipeline 0 this cycle |
| retire_p1 | input | 1 | Instruction completed in pipeline 1 this cycle |
| br_taken | input | 1 | A branch was taken this cycle |
| br_target | input | 32 | Target address of the taken branch |
| rd_req | input | 1 | Debug read request |
| trace_clr | input | 1 | Clear pulse for the overflow flag and the halt request |
| rd_data | output | 48 | Record returned by the last read, {target, count} |
| rd_valid | output | 1 | rd_data holds a record read in the previous cycle |
| buf_empty | output | 1 | Store holds no records |
| halt_req | output | 1 | Request to the core to enter debug halt |
| overflow | output | 1 | Sticky: a record was overwritten in wrap mode |
| drop_count | output | 16 | Saturating count of branches dropped while halted |

## Verification
The hardest state to reach from the ports is a saturated tally. It takes more than 32,000 cycles with both completion strobes active and no branch, so the bench runs exactly that long stretch and then takes a branch to read the clamped count back. The other hard case is the halt release rule, which needs a full store in stop mode, extra branches that are dropped, a clear that must have no effect, then a read and a second clear. The bench builds that sequence step by step and checks the request and the drop tally after each step.

// File: rtl/btb_pkg.sv
package btb_pkg;
  localparam int unsigned ADDR_W  = 32;
  localparam int unsigned CNT_W   = 16;
  localparam int unsigned ENTRY_W = ADDR_W + CNT_W;
endpackage

// File: rtl/btb_incident_ctr.sv
module btb_incident_ctr #(
  parameter int unsigned W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         inc_a,
  input  logic         inc_b,
  input  logic         restart,
  output logic [W-1:0] total
);
  localparam logic [W-1:0] MAXV = '1;

  logic [W-1:0] cnt_q;
  logic [W:0]   wide;

  always_comb begin
    wide  = {1'b0, cnt_q} + {{W{1'b0}}, inc_a} + {{W{1'b0}}, inc_b};
    total = wide[W] ? MAXV : wide[W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst)          cnt_q <= '0;
    else if (restart) cnt_q <= '0;
    else              cnt_q <= total;
  end

  assert_sat_hold_R3: assert property (@(posedge clk) disable iff (rst)
    (cnt_q == MAXV && !restart) |=> (cnt_q == MAXV));
  assert_restart_zero_R2: assert property (@(posedge clk) disable iff (rst)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/btb_ring.sv
module btb_ring #(
  parameter int unsigned DW    = 48,
  parameter int unsigned DEPTH = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          wr_en,
  input  logic [DW-1:0] wr_data,
  input  logic          allow_ovw,
  input  logic          rd_en,
  output logic [DW-1:0] rd_data,
  output logic          rd_valid,
  output logic          empty,
  output logic          full,
  output logic          pop,
  output logic          accepted,
  output logic          ovw,
  output logic          will_fill
);
  localparam int unsigned AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int unsigned CW = $clog2(DEPTH + 1);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);
  localparam logic [CW-1:0] FULLC = CW'(DEPTH);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wp_q, rp_q;
  logic [CW-1:0] cnt_q;

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == LAST) ? '0 : p + 1'b1;
  endfunction

  always_comb begin
    empty     = (cnt_q == '0);
    full      = (cnt_q == FULLC);
    pop       = rd_en && !empty;
    ovw       = wr_en && full && !pop && allow_ovw;
    accepted  = wr_en && (!full || pop || allow_ovw);
    will_fill = accepted && !pop && (cnt_q == FULLC - 1'b1);
  end

  always_ff @(posedge clk) begin
    if (accepted) mem[wp_q] <= wr_data;
    if (pop)      rd_data   <= mem[rp_q];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wp_q     <= '0;
      rp_q     <= '0;
      cnt_q    <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= pop;
      if (accepted) wp_q <= nxt(wp_q);
      if (pop || ovw) rp_q <= nxt(rp_q);
      if (accepted && !pop && !ovw) cnt_q <= cnt_q + 1'b1;
      else if (pop && !accepted)    cnt_q <= cnt_q - 1'b1;
    end
  end

  assert_depth_bound_R4: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULLC);
  assert_empty_read_R5: assert property (@(posedge clk) disable iff (rst)
    (rd_en && empty) |=> !rd_valid);
  assert_ovw_stays_full_R7: assert property (@(posedge clk) disable iff (rst)
    ovw |=> full);
  assert_both_served_R6: assert property (@(posedge clk) disable iff (rst)
    (wr_en && rd_en && !empty) |=> ($stable(cnt_q) && rd_valid));
endmodule

// File: rtl/btb_halt_ctl.sv
module btb_halt_ctl #(
  parameter int unsigned DW_CNT = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              mode_stop,
  input  logic              fill_evt,
  input  logic              pop,
  input  logic              clr,
  input  logic              ovw_evt,
  input  logic              drop_evt,
  output logic              halt_req,
  output logic              overflow,
  output logic [DW_CNT-1:0] drop_cnt
);
  localparam logic [DW_CNT-1:0] DMAX = '1;

  logic popped_q;
  logic release_ok;

  assign release_ok = halt_req && clr && popped_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      halt_req <= 1'b0;
      popped_q <= 1'b0;
      overflow <= 1'b0;
      drop_cnt <= '0;
    end else begin
      if (release_ok) begin
        halt_req <= 1'b0;
        popped_q <= 1'b0;
        drop_cnt <= '0;
      end else begin
        if (mode_stop && fill_evt) halt_req <= 1'b1;
        if (halt_req && pop)       popped_q <= 1'b1;
        if (drop_evt && drop_cnt != DMAX) drop_cnt <= drop_cnt + 1'b1;
      end
      if (clr)          overflow <= 1'b0;
      else if (ovw_evt) overflow <= 1'b1;
    end
  end

  assert_release_needs_clr_R9: assert property (@(posedge clk) disable iff (rst)
    $fell(halt_req) |-> $past(clr));
  assert_ovf_source_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(overflow) |-> $past(ovw_evt));
  assert_ovf_clear_R10: assert property (@(posedge clk) disable iff (rst)
    clr |=> !overflow);
endmodule

// File: rtl/branch_trace_buf.sv
module branch_trace_buf #(
  parameter int unsigned DEPTH = 16
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         mode_stop,
  input  logic                         retire_p0,
  input  logic                         retire_p1,
  input  logic                         br_taken,
  input  logic [btb_pkg::ADDR_W-1:0]   br_target,
  input  logic                         rd_req,
  input  logic                         trace_clr,
  output logic [btb_pkg::ENTRY_W-1:0]  rd_data,
  output logic                         rd_valid,
  output logic                         buf_empty,
  output logic                         halt_req,
  output logic                         overflow,
  output logic [btb_pkg::CNT_W-1:0]    drop_count
);
  import btb_pkg::*;

  logic [CNT_W-1:0]   tally;
  logic [ENTRY_W-1:0] rec;
  logic wr_en, full, pop, accepted, ovw, will_fill;

  btb_incident_ctr #(.W(CNT_W)) u_ctr (
    .clk(clk), .rst(rst), .inc_a(retire_p0), .inc_b(retire_p1),
    .restart(br_taken), .total(tally)
  );

  assign rec   = {br_target, tally};
  assign wr_en = br_taken && !halt_req;

  btb_ring #(.DW(ENTRY_W), .DEPTH(DEPTH)) u_ring (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_data(rec),
    .allow_ovw(!mode_stop), .rd_en(rd_req), .rd_data(rd_data),
    .rd_valid(rd_valid), .empty(buf_empty), .full(full), .pop(pop),
    .accepted(accepted), .ovw(ovw), .will_fill(will_fill)
  );

  btb_halt_ctl #(.DW_CNT(CNT_W)) u_ctl (
    .clk(clk), .rst(rst), .mode_stop(mode_stop), .fill_evt(will_fill),
    .pop(pop), .clr(trace_clr), .ovw_evt(ovw),
    .drop_evt(br_taken && !accepted), .halt_req(halt_req),
    .overflow(overflow), .drop_cnt(drop_count)
  );

  assert_halt_blocks_R8: assert property (@(posedge clk) disable iff (rst)
    halt_req |-> !accepted);
  assert_drop_counts_R8: assert property (@(posedge clk) disable iff (rst)
    (halt_req && br_taken && !trace_clr && drop_count != '1) |=> (drop_count != '0));
  assert_capture_during_read_R11: assert property (@(posedge clk) disable iff (rst)
    (br_taken && rd_req && !halt_req && !buf_empty) |=> !buf_empty);
endmodule

// File: tb/sim_branch_trace_buf.sv
module sim_branch_trace_buf;
  logic clk = 1'b0, rst = 1'b1;
  logic mode_stop = 1'b0, retire_p0 = 1'b0, retire_p1 = 1'b0, br_taken = 1'b0;
  logic [31:0] br_target = '0;
  logic rd_req = 1'b0, trace_clr = 1'b0;
  logic [47:0] rd_data;
  logic rd_valid, buf_empty, halt_req, overflow;
  logic [15:0] drop_count;

  int total = 0, bad = 0;
  logic [47:0] expq[$];
  int mcount = 0;
  int acc = 0;
  bit mhalt = 0, mpopped = 0, movf = 0;
  int mdrop = 0;
  bit done = 0;

  always #5 clk = ~clk;

  branch_trace_buf u0 (
    .clk(clk), .rst(rst), .mode_stop(mode_stop), .retire_p0(retire_p0),
    .retire_p1(retire_p1), .br_taken(br_taken), .br_target(br_target),
    .rd_req(rd_req), .trace_clr(trace_clr), .rd_data(rd_data),
    .rd_valid(rd_valid), .buf_empty(buf_empty), .halt_req(halt_req),
    .overflow(overflow), .drop_count(drop_count)
  );

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: every returned record is compared with the scoreboard head
  always @(negedge clk) begin
    if (!rst && rd_valid) begin
      if (expq.size() == 0) chk("R5 unexpected record", 64'(rd_data), 64'hDEAD);
      else chk("R4 record order/content", 64'(rd_data), 64'(expq.pop_front()));
    end
  end

  // driver: applies one cycle of stimulus and updates the model for that edge
  task automatic step(input bit a, input bit b, input bit br, input logic [31:0] tgt,
                      input bit rd, input bit clr);
    int sum;
    bit pop;
    @(negedge clk);
    retire_p0 = a; retire_p1 = b; br_taken = br; br_target = tgt;
    rd_req = rd; trace_clr = clr;
    sum = acc + int'(a) + int'(b);
    if (sum > 65535) sum = 65535;
    pop = rd && (mcount > 0);
    if (clr && mhalt && mpopped) begin
      mhalt = 0; mpopped = 0; mdrop = 0;
    end else begin
      if (br) begin
        if (mhalt) begin
          if (mdrop < 65535) mdrop++;
        end else if (mcount == 16 && !pop) begin
          if (!mode_stop) begin
            void'(expq.pop_front());
            expq.push_back({tgt, 16'(sum)});
            movf = 1;
          end
        end else begin
          expq.push_back({tgt, 16'(sum)});
          if (mode_stop && !pop && mcount == 15) mhalt = 1;
          mcount++;
        end
      end
      if (mhalt && pop) mpopped = 1;
    end
    if (pop) mcount--;
    if (clr) movf = 0;
    else if (br && !mhalt && mcount == 16 && !mode_stop && !pop && movf) movf = 1;
    acc = br ? 0 : sum;
  endtask

  task automatic idle();
    step(0, 0, 0, 32'h0, 0, 0);
  endtask

  task automatic check_state(input string req);
    chk({req, " empty"}, 64'(buf_empty), 64'(mcount == 0));
    chk({req, " halt"}, 64'(halt_req), 64'(mhalt));
    chk({req, " overflow"}, 64'(overflow), 64'(movf));
    chk({req, " drops"}, 64'(drop_count), 64'(mdrop));
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst = 1'b1; mode_stop = m;
    retire_p0 = 0; retire_p1 = 0; br_taken = 0; rd_req = 0; trace_clr = 0;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    expq.delete(); mcount = 0; acc = 0; mhalt = 0; mpopped = 0; movf = 0; mdrop = 0;
  endtask

  task automatic drain();
    while (mcount > 0) step(0, 0, 0, 32'h0, 1, 0);
    idle(); idle();
  endtask

  initial begin
    // R1: reset state
    do_reset(0);
    chk("R1 empty", 64'(buf_empty), 64'd1);
    chk("R1 valid", 64'(rd_valid), 64'd0);
    chk("R1 halt", 64'(halt_req), 64'd0);
    chk("R1 overflow", 64'(overflow), 64'd0);
    chk("R1 drops", 64'(drop_count), 64'd0);

    // R5: read from empty gives no valid
    step(0, 0, 0, 32'h0, 1, 0);
    idle();
    chk("R5 empty read valid", 64'(rd_valid), 64'd0);

    // R2: tally of 0/1/2 per cycle, including the branch cycle
    step(1, 0, 0, 32'h0, 0, 0);
    step(1, 1, 0, 32'h0, 0, 0);
    step(0, 1, 1, 32'h1000_0040, 0, 0);   // R2: 1+2+1 = 4
    step(0, 0, 1, 32'h1000_0080, 0, 0);   // R2: restart, 0
    step(1, 1, 1, 32'h2000_0000, 0, 0);   // R2: 2
    idle();
    check_state("R2");
    drain();
    check_state("R4 after drain");

    // R6/R11: push and pop together; capture continues while reading
    step(1, 0, 1, 32'hA000_0001, 0, 0);
    step(0, 1, 1, 32'hA000_0002, 0, 0);
    step(1, 1, 1, 32'hA000_0003, 1, 0);   // R6: both served
    step(0, 0, 1, 32'hA000_0004, 1, 0);   // R11
    idle();
    chk("R6 count after both", 64'(mcount), 64'd2);
    check_state("R11");
    drain();

    // R3: saturation of the tally
    for (int i = 0; i < 32768; i++) step(1, 1, 0, 32'h0, 0, 0);
    step(1, 1, 1, 32'h3000_0000, 0, 0);   // R3: expects 16'hFFFF
    step(0, 0, 1, 32'h3000_0004, 0, 0);   // R3: restart after saturation
    idle();
    drain();

    // R7/R10: wrap mode overwrite
    do_reset(0);
    for (int i = 0; i < 18; i++) step(i[0], 1, 1, 32'hC000_0000 + 32'(i), 0, 0);
    idle();
    chk("R7 overflow set", 64'(overflow), 64'd1);
    check_state("R7");
    drain();
    step(0, 0, 0, 32'h0, 0, 1);
    idle();
    chk("R10 overflow cleared", 64'(overflow), 64'd0);

    // R8/R9: stop mode
    do_reset(1);
    for (int i = 0; i < 16; i++) step(1, 0, 1, 32'h5000_0000 + 32'(i), 0, 0);
    idle();
    chk("R8 halt raised", 64'(halt_req), 64'd1);
    for (int i = 0; i < 3; i++) step(0, 1, 1, 32'h6000_0000 + 32'(i), 0, 0);
    idle();
    chk("R8 drop count", 64'(drop_count), 64'd3);
    check_state("R8");
    step(0, 0, 0, 32'h0, 0, 1);            // R9: clear without a read
    idle();
    chk("R9 clear ignored", 64'(halt_req), 64'd1);
    chk("R9 drops kept", 64'(drop_count), 64'd3);
    step(0, 0, 0, 32'h0, 1, 0);
    idle();
    step(0, 0, 0, 32'h0, 0, 1);            // R9: clear after a read
    idle();
    chk("R9 halt released", 64'(halt_req), 64'd0);
    chk("R9 drops zeroed", 64'(drop_count), 64'd0);
    step(1, 1, 1, 32'h7000_0000, 0, 0);   // capture resumes
    idle();
    check_state("R9");
    drain();
    check_state("R4 final");
    done = 1;
  end

  initial begin
    int cyc = 0;
    while (!done && cyc < 150000) begin
      @(posedge clk);
      cyc++;
    end
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=%0d expected=done", cyc);
    end
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule